// File: doc/BRIEF.md
# Synchronous burst SRAM control front-end

This block models the clocked control of a single-ported synchronous burst SRAM that holds a small internal array. At each rising clock edge it samples a snooze input, three chip enables, two address strobes, an advance input and the write controls. From these it sorts the cycle into one of the following:

- power-down;
- deselect;
- idle;
- a new burst at the external address;
- a burst step to the next address;
- a burst hold at the current address.

The processor-side strobe (`adsp_n`) always starts a read. It is ignored while `ce1_n` is high. Writes start only through the controller-side strobe (`adsc_n`), or on later clocks of a burst.

A 32-bit bidirectional bus carries write data into the block and registered read data out of it. Read data appears in the cycle after the access edge. The output driver is gated by an asynchronous output enable. That gate is masked whenever the current inputs form a write cycle, so that the bus can be turned around on the very next clock after a read.

The burst counter wraps inside an aligned group of four words. Only the two low address bits change. Byte lanes are written selectively from four byte enables, unless global write forces all four lanes.

Top module: `sburst_sram_ctl`

## Requirements
- R1: When `snooze` is high, no array write takes place, the bus is high impedance in that cycle, and it remains high impedance in the following cycle.
- R2: An active strobe on a deselected chip ends the burst and writes nothing. An active strobe here means `adsc_n` low, or `adsp_n` low together with `ce1_n` low. The chip is deselected when `ce1_n` is high, `ce2` is low, or `ce3_n` is high. The bus is high impedance in the next cycle, and later step or hold cycles stay idle until a new burst starts.
- R3: While `ce1_n` is high, `adsp_n` has no effect. With `adsc_n` high, the cycle is a step or a hold of the running burst.
- R4: `adsp_n` low with the chip selected starts a read burst at `addr`, whatever the values of `gw_n`, `bwe_n` and `bw_n`.
- R5: `adsc_n` low, with `adsp_n` high and the chip selected, starts a burst at `addr`. The burst is a write when the decoded write is active, and a read otherwise.
- R6: With both strobes inactive in a running burst, `adv_n` low steps the address. The low two bits increment modulo 4 and the upper bits stay the same, so 0x23 is followed by 0x20. The cycle is a read or a write according to the decoded write.
- R7: Under the same strobe conditions with `adv_n` high, the current address is reused for a read or a write.
- R8: The decoded write is active when `gw_n` is low, or when `bwe_n` is low and at least one bit of `bw_n` is low. When `gw_n`, `bwe_n` and all of `bw_n` are high, the decoded write is inactive.
- R9: A write with `gw_n` high updates only the byte lanes whose `bw_n` bit is low. Bit i controls `dq[8i+7:8i]`. A write with `gw_n` low updates all four lanes.
- R10: Read data for an access at edge k drives `dq` from edge k until edge k+1, but only while `oe_n` is low. `oe_n` acts at once, without a clock.
- R11: While the current inputs form a write cycle, the block does not drive `dq`, even when a read from the previous edge is pending and `oe_n` is low.
- R12: After reset, no burst is active and `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snooze | input | 1 | Power-down request, active high |
| ce1_n | input | 1 | Chip enable 1, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | External word address (AW = log2 DEPTH) |
| dq | inout | 32 | Bidirectional data bus |

## Verification
Two functions can fall into the same cycle: the registered read output left by the previous edge, and a write cycle that the current inputs present. The bench provokes this by following a read directly with a controller-strobe write while `oe_n` stays low, and by driving the write data on the bus itself. The check is that the bus carries exactly the bench's data in that cycle, with no read word mixed in, and that the array later returns that data. Snooze arriving while a read is pending is handled the same way: the bus must be high impedance in the snooze cycle and in the cycle after it.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
  localparam int LANE_W  = 8;
  localparam int BURST_W = 2;

  typedef enum logic [2:0] {
    CY_SLEEP,
    CY_DESEL,
    CY_IDLE,
    CY_NEW_RD,
    CY_NEW_WR,
    CY_STEP,
    CY_HOLD
  } cyc_e;
endpackage

// File: rtl/sburst_decode.sv
module sburst_decode
  import sburst_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              snooze,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic              burst_act,
  output cyc_e              cyc,
  output logic              wr_dec,
  output logic [NBYTES-1:0] lanes
);
  logic sel;
  logic p_strobe;

  always_comb begin
    wr_dec   = !gw_n || (!bwe_n && (bw_n != '1));
    lanes    = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
    sel      = !ce1_n && ce2 && !ce3_n;
    p_strobe = !adsp_n && !ce1_n;
    if (snooze)                   cyc = CY_SLEEP;
    else if (p_strobe || !adsc_n) begin
      if (!sel)                   cyc = CY_DESEL;
      else if (p_strobe)          cyc = CY_NEW_RD;
      else                        cyc = wr_dec ? CY_NEW_WR : CY_NEW_RD;
    end
    else if (!burst_act)          cyc = CY_IDLE;
    else                          cyc = adv_n ? CY_HOLD : CY_STEP;
  end
endmodule

// File: rtl/sburst_addr.sv
module sburst_addr
  import sburst_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          acc,
  input  logic [AW-1:0] ext,
  output logic [AW-1:0] eff,
  output logic [AW-1:0] base_q
);
  logic [BURST_W-1:0] low_nxt;

  always_comb begin
    low_nxt = base_q[BURST_W-1:0] + BURST_W'(1);
    if (load)      eff = ext;
    else if (step) eff = {base_q[AW-1:BURST_W], low_nxt};
    else           eff = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   base_q <= '0;
    else if (acc) base_q <= eff;
  end
endmodule

// File: rtl/sburst_array.sv
module sburst_array
  import sburst_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int NBYTES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = NBYTES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [NBYTES-1:0] lanes,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] rd_word;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lanes[g]) mem[addr] <= din[g*LANE_W +: LANE_W];
    end
    assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_word;
  end
endmodule

// File: rtl/sburst_sram_ctl.sv
module sburst_sram_ctl
  import sburst_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int NBYTES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = NBYTES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snooze,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic              oe_n,
  input  logic [AW-1:0]     addr,
  inout  wire  [DW-1:0]     dq
);
  cyc_e              cyc;
  logic              wr_dec;
  logic [NBYTES-1:0] lanes;
  logic              burst_act;
  logic              rd_q;
  logic              is_new, is_acc, we, re;
  logic [AW-1:0]     eff_addr, base_q;
  logic [DW-1:0]     rdata;
  logic              dq_oe;

  sburst_decode #(.NBYTES(NBYTES)) u_dec (
    .snooze(snooze), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .burst_act(burst_act),
    .cyc(cyc), .wr_dec(wr_dec), .lanes(lanes)
  );

  always_comb begin
    is_new = (cyc == CY_NEW_RD) || (cyc == CY_NEW_WR);
    is_acc = is_new || (cyc == CY_STEP) || (cyc == CY_HOLD);
    we     = (cyc == CY_NEW_WR) ||
             (((cyc == CY_STEP) || (cyc == CY_HOLD)) && wr_dec);
    re     = is_acc && !we;
  end

  sburst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(is_new), .step(cyc == CY_STEP),
    .acc(is_acc), .ext(addr), .eff(eff_addr), .base_q(base_q)
  );

  sburst_array #(.DEPTH(DEPTH), .NBYTES(NBYTES)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .lanes(lanes),
    .addr(eff_addr), .din(dq), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      rd_q      <= 1'b0;
    end else begin
      rd_q <= re;
      if (cyc == CY_DESEL) burst_act <= 1'b0;
      else if (is_new)     burst_act <= 1'b1;
    end
  end

  assign dq_oe = rd_q && !oe_n && !snooze && !we;
  assign dq    = dq_oe ? rdata : 'z;
endmodule

// File: rtl/sburst_chk.sv
module sburst_chk
  import sburst_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          snooze,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          adsp_n,
  input logic          adsc_n,
  input logic          gw_n,
  input logic          bwe_n,
  input cyc_e          cyc,
  input logic          we,
  input logic          rd_q,
  input logic [AW-1:0] base_q
);
  logic desel_in;
  assign desel_in = !snooze && ((!adsp_n && !ce1_n) || !adsc_n) &&
                    (ce1_n || !ce2 || ce3_n);

  a_r1_snooze_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> !rd_q);

  a_r1_snooze_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !we);

  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    desel_in |=> !rd_q);

  a_r4_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !adsp_n && !ce1_n && ce2 && !ce3_n) |-> !we);

  a_r6_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_STEP) |=> (base_q[1:0] == $past(base_q[1:0]) + 2'd1) &&
                         (base_q[AW-1:2] == $past(base_q[AW-1:2])));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_HOLD) |=> $stable(base_q));

  a_r8_no_write_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> !we);
endmodule

bind sburst_sram_ctl sburst_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .snooze(snooze), .ce1_n(ce1_n), .ce2(ce2),
  .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .gw_n(gw_n),
  .bwe_n(bwe_n), .cyc(cyc), .we(we), .rd_q(rd_q), .base_q(base_q)
);

// File: tb/test_sburst_sram_ctl.sv
`timescale 1ns/1ps
module test_sburst_sram_ctl;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          snooze, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n;
  logic          gw_n, bwe_n, oe_n;
  logic [3:0]    bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] tb_dq;
  logic          tb_en;
  wire  [DW-1:0] dq;
  assign dq = tb_en ? tb_dq : 'z;

  sburst_sram_ctl i_sburst_sram_ctl (
    .clk(clk), .rst_n(rst_n), .snooze(snooze), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
    .dq(dq)
  );

  // staged stimulus
  logic s_sn, s_c1, s_c2, s_c3, s_p, s_c, s_adv, s_gw, s_bwe, s_oe;
  logic [3:0]    s_bw;
  logic [AW-1:0] s_a;
  logic [DW-1:0] s_wd;

  // reference model state
  logic [DW-1:0] m_mem [256];
  logic [AW-1:0] m_base;
  logic          m_act, m_rd;
  logic [DW-1:0] m_rdata;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic idle();
    s_sn = 0; s_c1 = 0; s_c2 = 1; s_c3 = 0; s_p = 1; s_c = 1; s_adv = 1;
    s_gw = 1; s_bwe = 1; s_bw = 4'hF; s_oe = 0; s_a = '0; s_wd = '0;
  endtask

  task automatic step(input string tag);
    logic sel, pstr, wrd, neww, newr, stp, hld, we, desel;
    logic [3:0]    ln;
    logic [AW-1:0] ea;
    @(posedge clk);
    #1;
    snooze = s_sn; ce1_n = s_c1; ce2 = s_c2; ce3_n = s_c3; adsp_n = s_p;
    adsc_n = s_c; adv_n = s_adv; gw_n = s_gw; bwe_n = s_bwe; bw_n = s_bw;
    oe_n = s_oe; addr = s_a;
    sel   = !s_c1 && s_c2 && !s_c3;
    pstr  = !s_p && !s_c1;
    wrd   = !s_gw || (!s_bwe && s_bw != 4'hF);
    ln    = !s_gw ? 4'hF : (!s_bwe ? ~s_bw : 4'h0);
    desel = !s_sn && (pstr || !s_c) && !sel;
    newr  = !s_sn && sel && (pstr || (!s_c && !wrd));
    neww  = !s_sn && sel && !pstr && !s_c && wrd;
    stp   = !s_sn && !pstr && s_c && m_act && !s_adv;
    hld   = !s_sn && !pstr && s_c && m_act && s_adv;
    we    = neww || ((stp || hld) && wrd);
    tb_en = we;
    tb_dq = s_wd;
    if (we) exp_q.push_back(s_wd);
    else if (m_rd && !s_oe && !s_sn) exp_q.push_back(m_rdata);
    else exp_q.push_back('z);
    tag_q.push_back(tag);
    ea = (newr || neww) ? s_a : (stp ? {m_base[AW-1:2], m_base[1:0] + 2'd1} : m_base);
    if (we) for (int i = 0; i < 4; i++)
      if (ln[i]) m_mem[ea][8*i +: 8] = s_wd[8*i +: 8];
    m_rd = (newr || stp || hld) && !we;
    if (m_rd) m_rdata = m_mem[ea];
    if (newr || neww || stp || hld) m_base = ea;
    if (desel) m_act = 0;
    else if (newr || neww) m_act = 1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (dq !== e) begin
          errors++;
          $display("FAIL %s: dq=%h expected %h", t, dq, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_base = '0; m_act = 0; m_rd = 0; m_rdata = '0;
    idle();
    snooze = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1;
    adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; addr = '0;
    tb_en = 0; tb_dq = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dq !== 'z) begin
      errors++;
      $display("FAIL R12 reset: dq=%h expected %h", dq, 32'hzzzzzzzz);
    end
    idle(); step("R12 no burst after reset");

    // clear the words used later so the array matches the model
    idle(); s_c = 0; s_gw = 0; s_a = 8'h40; s_wd = '0; step("R5 clear 0x40");
    idle(); s_c = 0; s_gw = 0; s_a = 8'h41; s_wd = '0; step("R5 clear 0x41");

    // write burst with wrap
    idle(); s_c = 0; s_gw = 0; s_a = 8'h22; s_wd = 32'h11111111; step("R5 new write");
    idle(); s_adv = 0; s_gw = 0; s_wd = 32'h22222222; step("R6 step write");
    idle(); s_adv = 0; s_gw = 0; s_wd = 32'h33333333; step("R6 wrap write");
    idle(); s_adv = 0; s_gw = 0; s_wd = 32'h44444444; step("R6 step write");
    idle(); s_gw = 0; s_wd = 32'h55555555; step("R7 hold write");
    idle(); s_oe = 1; step("R7 hold read oe high");

    // processor-strobe read with write controls active
    idle(); s_p = 0; s_gw = 0; s_bwe = 0; s_bw = 4'h0; s_a = 8'h22; s_oe = 1;
    step("R4 adsp read start");
    idle(); s_adv = 0; step("R4 R10 data of 0x22");
    idle(); s_adv = 0; step("R6 data of 0x23");
    idle(); s_adv = 0; step("R6 data of 0x20");
    idle(); step("R6 data of 0x21");
    idle(); s_c1 = 1; s_p = 0; s_adv = 0; step("R7 data of 0x21 again");
    idle(); step("R3 adsp ignored, stepped to 0x22");
    idle(); s_oe = 1; step("R10 oe high floats bus");
    idle(); step("R10 oe low drives again");

    // byte lanes and write decode
    idle(); s_c = 0; s_bwe = 0; s_bw = 4'b1010; s_a = 8'h40; s_wd = 32'hAABBCCDD;
    step("R9 byte lanes 0 and 2");
    idle(); s_c = 0; s_bw = 4'h0; s_a = 8'h40; s_oe = 1; step("R8 bwe high no write");
    idle(); step("R9 R8 lanes readback");
    idle(); s_c = 0; s_gw = 0; s_bwe = 1; s_bw = 4'hF; s_a = 8'h41; s_wd = 32'h0F0F0F0F;
    step("R9 gw writes all lanes");

    // read then immediate write with oe low
    idle(); s_c = 0; s_a = 8'h40; step("R5 read 0x40");
    idle(); s_c = 0; s_gw = 0; s_a = 8'h41; s_wd = 32'h12345678;
    step("R11 write masks pending read");
    idle(); s_c = 0; s_a = 8'h41; step("R5 read 0x41");
    idle(); step("R11 written word read back");

    // deselects
    idle(); s_c = 0; s_c2 = 0; s_gw = 0; s_a = 8'h40; s_wd = 32'hDEADBEEF;
    step("R2 deselect ce2, read still out");
    idle(); s_adv = 0; s_gw = 0; s_wd = 32'hDEADBEEF; step("R2 floats, burst ended");
    idle(); s_gw = 0; s_wd = 32'hDEADBEEF; step("R2 idle hold no write");
    idle(); s_c = 0; s_a = 8'h40; step("R5 read 0x40 after deselect");
    idle(); s_c1 = 1; s_c = 0; step("R2 R3 ce1 high with adsc");
    idle(); step("R2 floats after ce1 deselect");
    idle(); s_c = 0; s_c3 = 1; s_a = 8'h40; step("R2 ce3 deselect");
    idle(); step("R2 floats after ce3 deselect");
    idle(); s_c = 0; s_a = 8'h40; step("R5 read 0x40 unchanged");

    // snooze
    idle(); s_sn = 1; s_c = 0; s_gw = 0; s_a = 8'h40; step("R1 snooze floats pending read");
    idle(); step("R1 floats cycle after snooze");
    idle(); s_sn = 1; step("R1 snooze again");
    idle(); s_c = 0; s_a = 8'h40; step("R5 read 0x40 after snooze");
    idle(); step("R1 no write during snooze");
    idle(); step("R7 hold read again");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule